// File: doc/BRIEF.md
# Broadcast register bank with OR-combined read data

This block holds a small set of 32-bit control/status registers that all sit on one shared register bus. A single bus master drives an address, a read strobe, a write strobe and write data. Those four go, untouched, to every register endpoint in the bank. Each endpoint owns one fixed address. It takes part in a transfer only when the bus address equals its own.

For reads there is no central multiplexer. Every endpoint presents its stored word on a private read lane only while it is selected for a read. At all other times it holds that lane at zero. The bank's read data is the bitwise OR of all lanes. A write stores the bus data into the addressed register at the next rising clock edge.

Each register's current contents also leave the block on a dedicated value output, so nearby logic can use them as configuration. The register count, the address of each register and the reset value of each register are parameters. The addresses must be distinct, and elaboration stops with an error when two of them are equal.

Top module: `regbank_top`

## Requirements
- R1: While `rst` is high at a rising edge, every register loads its reset value at that edge (synchronous reset). The defaults are: register 0 = 0x00000000, register 1 = 0x12345678, register 2 = 0xFFFF0000, register 3 = 0x0000A5A5.
- R2: When `bus_rd_en` is high and `bus_addr` equals a register's address, `bus_rdata` shows that register's current value in the same cycle. The default addresses are: register 0 = 0x0000, register 1 = 0x0004, register 2 = 0x0008, register 3 = 0x0100.
- R3: While `bus_rd_en` is low, `bus_rdata` is all zeros, whatever the address.
- R4: A read of an address that matches no register returns all zeros.
- R5: When `bus_wr_en` is high and `bus_addr` equals a register's address, that register holds `bus_wdata` after the next rising edge.
- R6: A write to an address that matches no register changes no register.
- R7: While `bus_wr_en` is low, no register changes, whatever the address and write data.
- R8: When read and write strobes are high in the same cycle at one address, `bus_rdata` shows the old value in that cycle, and the new value is present after the edge.
- R9: The value of register i is always present on `reg_values[i*32 +: 32]`, independent of bus activity.
- R10: A write to one register leaves every other register unchanged.
- R11: Address matching compares all 16 address bits. An address that differs from a register's address only in the upper bits (for example 0x8004) neither reads nor writes that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Bus address, sent to every endpoint |
| bus_rd_en | input | 1 | Read strobe |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, sent to every endpoint |
| bus_rdata | output | 32 | OR of all endpoint read lanes |
| reg_values | output | 32*N_REGS | Current contents of every register, register i at bits i*32 +: 32 |

## Verification
The bench targets the cases where a slack endpoint leaks onto the shared OR. Reads with the read strobe low and reads of unmapped or upper-bit-aliased addresses would show stale or merged words if an endpoint stopped masking its lane. Writes with the strobe low, writes to unmapped addresses and writes to a neighbour would corrupt registers if the write gate or the full-width compare were weakened. A combined read-and-write cycle is sampled before and after the edge: a design that read back the write data combinationally would fail there. A second reset in the middle of the run checks that every register returns to its own reset value.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int BUS_ADDR_W = 16;
    localparam int BUS_DATA_W = 32;

    // Request side of the register bus, broadcast to every endpoint
    typedef struct packed {
        logic [BUS_ADDR_W-1:0] addr;
        logic                  rd_en;
        logic                  wr_en;
        logic [BUS_DATA_W-1:0] wdata;
    } bus_req_t;

endpackage

// File: rtl/regbank_endpoint.sv
module regbank_endpoint
    import regbank_pkg::*;
#(
    parameter logic [BUS_ADDR_W-1:0] MY_ADDR = '0,
    parameter logic [BUS_DATA_W-1:0] RST_VAL = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  bus_req_t              req,
    output logic [BUS_DATA_W-1:0] rd_lane,
    output logic [BUS_DATA_W-1:0] value
);

    typedef struct packed {
        logic [BUS_DATA_W-1:0] data;
    } ep_state_t;

    ep_state_t state_d, state_q;
    logic      sel_d;

    always_comb begin
        sel_d   = (req.addr == MY_ADDR);
        state_d = state_q;
        if (rst) begin
            state_d.data = RST_VAL;
        end else if (sel_d && req.wr_en) begin
            state_d.data = req.wdata;
        end
        // Lane must stay zero unless selected for a read; the bank ORs all lanes
        rd_lane = (sel_d && req.rd_en) ? state_q.data : '0;
        value   = state_q.data;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

endmodule

// File: rtl/regbank_or_reduce.sv
module regbank_or_reduce
    import regbank_pkg::*;
#(
    parameter int N_IN = 4
) (
    input  logic [N_IN-1:0][BUS_DATA_W-1:0] lanes,
    output logic [BUS_DATA_W-1:0]           merged
);

    logic [N_IN:0][BUS_DATA_W-1:0] acc;

    assign acc[0] = '0;

    for (genvar i = 0; i < N_IN; i++) begin : g_or
        assign acc[i+1] = acc[i] | lanes[i];
    end

    assign merged = acc[N_IN];

endmodule

// File: rtl/regbank_top.sv
module regbank_top
    import regbank_pkg::*;
#(
    parameter int                                N_REGS    = 4,
    parameter logic [N_REGS*BUS_ADDR_W-1:0]      REG_ADDRS = {16'h0100, 16'h0008, 16'h0004, 16'h0000},
    parameter logic [N_REGS*BUS_DATA_W-1:0]      RST_VALS  = {32'h0000A5A5, 32'hFFFF0000,
                                                              32'h12345678, 32'h00000000}
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [15:0]                  bus_addr,
    input  logic                         bus_rd_en,
    input  logic                         bus_wr_en,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic [N_REGS*32-1:0]         reg_values
);

    localparam int VAL_W = N_REGS * BUS_DATA_W;

    bus_req_t                            req;
    logic [N_REGS-1:0][BUS_DATA_W-1:0]   lanes;
    logic [N_REGS-1:0][BUS_DATA_W-1:0]   vals;

    assign req = '{addr: bus_addr, rd_en: bus_rd_en, wr_en: bus_wr_en, wdata: bus_wdata};

    // Distinct addresses are required for the OR combine to stay correct
    for (genvar i = 0; i < N_REGS; i++) begin : g_dup_i
        for (genvar j = i + 1; j < N_REGS; j++) begin : g_dup_j
            if (REG_ADDRS[i*BUS_ADDR_W +: BUS_ADDR_W] == REG_ADDRS[j*BUS_ADDR_W +: BUS_ADDR_W]) begin : g_bad
                $error("regbank_top: registers %0d and %0d share an address", i, j);
            end
        end
    end

    for (genvar i = 0; i < N_REGS; i++) begin : g_ep
        regbank_endpoint #(
            .MY_ADDR (REG_ADDRS[i*BUS_ADDR_W +: BUS_ADDR_W]),
            .RST_VAL (RST_VALS[i*BUS_DATA_W +: BUS_DATA_W])
        ) u_ep (
            .clk     (clk),
            .rst     (rst),
            .req     (req),
            .rd_lane (lanes[i]),
            .value   (vals[i])
        );
    end

    regbank_or_reduce #(
        .N_IN (N_REGS)
    ) u_or (
        .lanes  (lanes),
        .merged (bus_rdata)
    );

    assign reg_values = VAL_W'(vals);

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
    import regbank_pkg::*;
#(
    parameter int                           N_REGS    = 4,
    parameter logic [N_REGS*BUS_ADDR_W-1:0] REG_ADDRS = '0,
    parameter logic [N_REGS*BUS_DATA_W-1:0] RST_VALS  = '0
) (
    input logic                  clk,
    input logic                  rst,
    input logic [15:0]           bus_addr,
    input logic                  bus_rd_en,
    input logic                  bus_wr_en,
    input logic [31:0]           bus_wdata,
    input logic [31:0]           bus_rdata,
    input logic [N_REGS*32-1:0]  reg_values
);

    logic any_hit;

    always_comb begin
        any_hit = 1'b0;
        for (int k = 0; k < N_REGS; k++) begin
            if (bus_addr == REG_ADDRS[k*BUS_ADDR_W +: BUS_ADDR_W]) any_hit = 1'b1;
        end
    end

    // R3
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |-> bus_rdata == '0);

    // R4
    miss_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_en && !any_hit) |-> bus_rdata == '0);

    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        localparam logic [BUS_ADDR_W-1:0] A = REG_ADDRS[i*BUS_ADDR_W +: BUS_ADDR_W];
        localparam logic [BUS_DATA_W-1:0] V = RST_VALS[i*BUS_DATA_W +: BUS_DATA_W];

        // R1
        reset_value_chk: assert property (@(posedge clk)
            rst |=> reg_values[i*32 +: 32] == V);

        // R2
        read_hit_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_rd_en && bus_addr == A) |-> bus_rdata == reg_values[i*32 +: 32]);

        // R5
        write_load_chk: assert property (@(posedge clk) disable iff (rst)
            (bus_wr_en && bus_addr == A) |=> reg_values[i*32 +: 32] == $past(bus_wdata));

        // R6 R7 R10
        hold_value_chk: assert property (@(posedge clk) disable iff (rst)
            !(bus_wr_en && bus_addr == A) |=> $stable(reg_values[i*32 +: 32]));
    end

endmodule

bind regbank_top regbank_chk #(
    .N_REGS    (N_REGS),
    .REG_ADDRS (REG_ADDRS),
    .RST_VALS  (RST_VALS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd_en  (bus_rd_en),
    .bus_wr_en  (bus_wr_en),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .reg_values (reg_values)
);

// File: tb/regbank_top_tb.sv
module regbank_top_tb;

    localparam int N = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [15:0]       bus_addr;
    logic              bus_rd_en;
    logic              bus_wr_en;
    logic [31:0]       bus_wdata;
    logic [31:0]       bus_rdata;
    logic [N*32-1:0]   reg_values;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [15:0] addr_of [N] = '{16'h0000, 16'h0004, 16'h0008, 16'h0100};
    logic [31:0] rst_of  [N] = '{32'h00000000, 32'h12345678, 32'hFFFF0000, 32'h0000A5A5};
    logic [31:0] model   [N];

    always #2 clk = ~clk;

    regbank_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_rd_en  (bus_rd_en),
        .bus_wr_en  (bus_wr_en),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .reg_values (reg_values)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < N; i++) chk(req, reg_values[i*32 +: 32], model[i]);
    endtask

    task automatic bus_idle();
        bus_addr = 16'h0; bus_rd_en = 1'b0; bus_wr_en = 1'b0; bus_wdata = 32'h0;
    endtask

    // Drive a write at the falling edge, let one rising edge pass, release
    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic en);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = en; bus_rd_en = 1'b0;
        @(posedge clk);
        #1;
        bus_idle();
        @(negedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bus_idle();
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < N; i++) model[i] = rst_of[i];
        #1;
    endtask

    task automatic t_reset();
        do_reset();
        chk_all("R1 reset value");
    endtask

    task automatic t_read_each();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            bus_addr = addr_of[i]; bus_rd_en = 1'b1;
            #1;
            chk("R2 read hit", bus_rdata, model[i]);
            chk("R9 value port", reg_values[i*32 +: 32], model[i]);
        end
        bus_idle();
    endtask

    task automatic t_rd_disabled();
        @(negedge clk);
        bus_addr = addr_of[1]; bus_rd_en = 1'b0;
        #1;
        chk("R3 read strobe low", bus_rdata, 32'h0);
        bus_addr = addr_of[2];
        #1;
        chk("R3 read strobe low", bus_rdata, 32'h0);
        bus_idle();
    endtask

    task automatic t_unmapped_read();
        @(negedge clk);
        bus_addr = 16'h0010; bus_rd_en = 1'b1;
        #1;
        chk("R4 unmapped read", bus_rdata, 32'h0);
        bus_addr = 16'h8004;
        #1;
        chk("R11 aliased read", bus_rdata, 32'h0);
        bus_idle();
    endtask

    task automatic t_write();
        do_write(addr_of[2], 32'hCAFEF00D, 1'b1);
        model[2] = 32'hCAFEF00D;
        chk("R5 write load", reg_values[2*32 +: 32], 32'hCAFEF00D);
        chk_all("R10 neighbours kept");
        do_write(addr_of[0], 32'h0BADF00D, 1'b1);
        model[0] = 32'h0BADF00D;
        chk_all("R5 write load");
    endtask

    task automatic t_unmapped_write();
        do_write(16'h0200, 32'h11111111, 1'b1);
        chk_all("R6 unmapped write");
        do_write(16'h8100, 32'h22222222, 1'b1);
        chk_all("R11 aliased write");
    endtask

    task automatic t_wr_disabled();
        do_write(addr_of[1], 32'h33333333, 1'b0);
        chk_all("R7 write strobe low");
    endtask

    task automatic t_rw_same();
        @(negedge clk);
        bus_addr = addr_of[3]; bus_rd_en = 1'b1; bus_wr_en = 1'b1; bus_wdata = 32'h5A5A0F0F;
        #1;
        chk("R8 old value read", bus_rdata, model[3]);
        @(posedge clk);
        #1;
        bus_wr_en = 1'b0;
        model[3] = 32'h5A5A0F0F;
        #1;
        chk("R8 new value after edge", bus_rdata, 32'h5A5A0F0F);
        bus_idle();
        chk_all("R8 bank state");
    endtask

    initial begin
        rst = 1'b1;
        bus_idle();
        repeat (2) @(posedge clk);
        t_reset();
        t_read_each();
        t_rd_disabled();
        t_unmapped_read();
        t_write();
        t_read_each();
        t_unmapped_write();
        t_wr_disabled();
        t_rw_same();
        t_reset();
        t_read_each();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule